// File: doc/BRIEF.md
# Flat Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It uses one flat page table in memory. The table has one entry for each of the 2^20 virtual pages, and the virtual page number indexes it directly. The table's start address comes from a base value that software loads for the running process and presents with every request.

A client offers a request when the block is ready. The block keeps the virtual address and the base, then works out where the entry for the page sits. It issues one read on a simple memory port and waits for the read data, however long the memory takes. If the entry's valid flag is set, the block joins the entry's frame number to the untouched page offset and returns that address. If the flag is clear, it returns no address. Instead it raises a page-fault indication and reports the page number that missed.

Only one translation is in flight at a time. Each result is presented for a single cycle.

Top module: `pt_walker`

## Requirements
- R1: After a synchronous reset, `req_ready` is 1 and `mem_req`, `rsp_valid` and `rsp_fault` are 0, and `rsp_paddr` and `rsp_vpn` are zero.
- R2: For each accepted request, `mem_req` is high for exactly one cycle. During that cycle `mem_addr` equals `req_base + vpn*4` modulo 2^32, where vpn is bits 31:12 of the virtual address.
- R3: If bit 0 of the returned 32-bit entry is 1, the response has `rsp_fault`=0. `rsp_paddr` holds entry bits 31:12 in bits 31:12, and virtual address bits 11:0 in bits 11:0.
- R4: If bit 0 of the returned entry is 0, the response has `rsp_fault`=1 and `rsp_paddr`=0. `rsp_vpn` equals bits 31:12 of the virtual address.
- R5: `rsp_valid` rises in the cycle after `mem_rvalid` is seen while waiting. It stays high for exactly one cycle, once per accepted request.
- R6: `req_ready` is high only when no translation is in progress. A `req_valid` held high during a translation starts no extra read and does not change the result.
- R7: Entry bits 11:1 have no effect on the translated address.
- R8: Virtual address 0x0000000A, with page 0 mapped to frame 5, translates to 0x0000500A.
- R9: While `rsp_valid` is 0, `rsp_fault` is 0 and `rsp_paddr` and `rsp_vpn` are zero.
- R10: A reset during a translation abandons it. No response follows, and the next request translates normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A translation request is offered |
| req_ready | output | 1 | The block is idle and takes a request this cycle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_base | input | 32 | Start address of the current process's page table |
| mem_req | output | 1 | Read strobe for one table entry |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data is present |
| mem_rdata | input | 32 | Entry word: frame in bits 31:12, valid flag in bit 0 |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | The response is a page fault |
| rsp_paddr | output | 32 | Translated physical address (zero on a fault) |
| rsp_vpn | output | 20 | Page number that faulted (zero otherwise) |

## Verification
The assertions check the following on every cycle:
- the response lasts one cycle;
- the response follows the read data by one cycle;
- each read strobe lasts one cycle;
- the ready flag drops once a request is taken;
- outputs stay quiet between responses;
- a fault carries no address.

Only the bench's scenarios can show the rest. These include the entry address arithmetic, the frame and offset joining, and that entry bits 11:1 are ignored. They also cover the worked example and the loss of a request held high while busy. Finally, they show an abandoned walk after a mid-flight reset. A memory model with random latency and a sparse table of random entries drives these checks.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_FETCH = 3'd1,
      ST_WAIT  = 3'd2,
      ST_DONE  = 3'd3,
      ST_FAULT = 3'd4
   } walk_state_t;
endpackage

// File: rtl/pgw_entry_addr.sv
module pgw_entry_addr #(
   parameter int PA_W      = 32,
   parameter int VPN_W     = 20,
   parameter int PTE_BYTES = 4
) (
   input  logic [PA_W-1:0]  base,
   input  logic [VPN_W-1:0] vpn,
   output logic [PA_W-1:0]  entry_addr
);
   localparam bit POW2 = (PTE_BYTES & (PTE_BYTES - 1)) == 0;
   localparam int SHIFT = $clog2(PTE_BYTES);

   if (PTE_BYTES < 1) begin : g_bad_bytes
      $error("PTE_BYTES must be at least 1");
   end
   if (VPN_W > PA_W) begin : g_bad_vpn
      $error("VPN_W must not exceed PA_W");
   end

   logic [PA_W-1:0] vpn_ext;
   assign vpn_ext = PA_W'(vpn);

   if (POW2) begin : g_shift
      assign entry_addr = base + (vpn_ext << SHIFT);
   end else begin : g_mult
      assign entry_addr = base + vpn_ext * PA_W'(PTE_BYTES);
   end
endmodule

// File: rtl/pgw_pte_decode.sv
module pgw_pte_decode #(
   parameter int PTE_W     = 32,
   parameter int OFS_W     = 12,
   parameter int PFN_W     = 20,
   parameter int VALID_BIT = 0
) (
   input  logic [PTE_W-1:0] pte,
   output logic             present,
   output logic [PFN_W-1:0] frame
);
   if (OFS_W + PFN_W > PTE_W) begin : g_bad_fit
      $error("frame field does not fit in the entry");
   end
   if (VALID_BIT >= OFS_W) begin : g_bad_valid
      $error("valid flag must sit below the frame field");
   end

   logic unused_pte_bits;
   assign unused_pte_bits = ^pte;

   assign present = pte[VALID_BIT];
   assign frame   = pte[OFS_W +: PFN_W];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
   import pgw_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int OFS_W     = 12,
   parameter int PTE_W     = 32,
   parameter int VALID_BIT = 0
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [VA_W-1:0]         req_vaddr,
   input  logic [PA_W-1:0]         req_base,
   output logic                    mem_req,
   output logic [PA_W-1:0]         mem_addr,
   input  logic                    mem_rvalid,
   input  logic [PTE_W-1:0]        mem_rdata,
   output logic                    rsp_valid,
   output logic                    rsp_fault,
   output logic [PA_W-1:0]         rsp_paddr,
   output logic [VA_W-OFS_W-1:0]   rsp_vpn
);
   localparam int VPN_W     = VA_W - OFS_W;
   localparam int PFN_W     = PA_W - OFS_W;
   localparam int PTE_BYTES = PTE_W / 8;

   if (OFS_W < 1 || OFS_W >= VA_W || OFS_W >= PA_W) begin : g_bad_ofs
      $error("OFS_W must be inside both address widths");
   end
   if (PTE_W % 8 != 0) begin : g_bad_pte
      $error("PTE_W must be a whole number of bytes");
   end

   walk_state_t      state_q;
   logic [VA_W-1:0]  vaddr_q;
   logic [PA_W-1:0]  base_q;
   logic [PFN_W-1:0] frame_q;
   logic             present;
   logic [PFN_W-1:0] frame;
   logic [PA_W-1:0]  entry_addr;

   pgw_entry_addr #(.PA_W(PA_W), .VPN_W(VPN_W), .PTE_BYTES(PTE_BYTES)) u_addr (
      .base       (base_q),
      .vpn        (vaddr_q[VA_W-1:OFS_W]),
      .entry_addr (entry_addr)
   );

   pgw_pte_decode #(.PTE_W(PTE_W), .OFS_W(OFS_W), .PFN_W(PFN_W), .VALID_BIT(VALID_BIT)) u_dec (
      .pte     (mem_rdata),
      .present (present),
      .frame   (frame)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         vaddr_q <= '0;
         base_q  <= '0;
         frame_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               vaddr_q <= req_vaddr;
               base_q  <= req_base;
               state_q <= ST_FETCH;
            end
            ST_FETCH: state_q <= ST_WAIT;
            ST_WAIT: if (mem_rvalid) begin
               frame_q <= frame;
               state_q <= present ? ST_DONE : ST_FAULT;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign mem_req   = (state_q == ST_FETCH);
   assign mem_addr  = entry_addr;
   assign rsp_valid = (state_q == ST_DONE) || (state_q == ST_FAULT);
   assign rsp_fault = (state_q == ST_FAULT);
   assign rsp_paddr = (state_q == ST_DONE) ? {frame_q, vaddr_q[OFS_W-1:0]} : '0;
   assign rsp_vpn   = (state_q == ST_FAULT) ? vaddr_q[VA_W-1:OFS_W] : '0;

   AST_ONE_CYCLE_RSP: assert property (@(posedge clk) disable iff (rst) rsp_valid |=> !rsp_valid); // R5
   AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
      (state_q == ST_WAIT && mem_rvalid) |=> rsp_valid); // R5
   AST_SINGLE_FETCH: assert property (@(posedge clk) disable iff (rst) mem_req |=> !mem_req); // R2
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
      (req_ready && req_valid) |=> !req_ready); // R6
   AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
      rsp_fault |-> (rsp_valid && rsp_paddr == '0)); // R4
   AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
      !rsp_valid |-> (!rsp_fault && rsp_paddr == '0 && rsp_vpn == '0)); // R9
   AST_NO_READ_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> !mem_req); // R6
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
   logic        clk = 1'b0;
   logic        rst;
   logic        req_valid;
   logic        req_ready;
   logic [31:0] req_vaddr;
   logic [31:0] req_base;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rvalid;
   logic [31:0] mem_rdata;
   logic        rsp_valid;
   logic        rsp_fault;
   logic [31:0] rsp_paddr;
   logic [19:0] rsp_vpn;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int nreq   = 0;

   logic [31:0] ptm [logic [31:0]];
   logic        pend;
   int          cnt;
   logic [31:0] cap_addr;

   logic [31:0] got_paddr;
   logic        got_fault;
   logic [19:0] got_vpn;
   logic        got_resp;

   always #2.5 clk = ~clk;

   pt_walker dut (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_base(req_base), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
      .rsp_vpn(rsp_vpn)
   );

   function automatic logic [31:0] lookup(input logic [31:0] a);
      return ptm.exists(a) ? ptm[a] : 32'h0;
   endfunction

   function automatic logic [31:0] exp_entry_addr(input logic [31:0] b, input logic [31:0] va);
      return b + {10'd0, va[31:12], 2'b00};
   endfunction

   function automatic logic [31:0] exp_paddr(input logic [31:0] pte, input logic [31:0] va);
      return pte[0] ? {pte[31:12], va[11:0]} : 32'h0;
   endfunction

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (rst) begin
         pend       <= 1'b0;
         mem_rvalid <= 1'b0;
         mem_rdata  <= 32'h0;
      end else begin
         mem_rvalid <= 1'b0;
         if (mem_req) begin
            pend     <= 1'b1;
            cnt      <= int'($urandom % 4);
            cap_addr <= mem_addr;
            nreq     <= nreq + 1;
         end else if (pend) begin
            if (cnt == 0) begin
               mem_rvalid <= 1'b1;
               mem_rdata  <= lookup(cap_addr);
               pend       <= 1'b0;
            end else begin
               cnt <= cnt - 1;
            end
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic translate(input logic [31:0] b, input logic [31:0] va, input bit hold_busy);
      int n0;
      int wait_n;
      n0 = nreq;
      got_resp = 1'b0;
      @(negedge clk);
      chk(req_ready, "R6 ready when idle", 32'(req_ready), 32'd1);
      req_valid = 1'b1;
      req_vaddr = va;
      req_base  = b;
      @(negedge clk);
      if (hold_busy) begin
         req_vaddr = ~va;
         req_base  = b ^ 32'h0000_1000;
      end else begin
         req_valid = 1'b0;
      end
      wait_n = 0;
      while (!rsp_valid && wait_n < 40) begin
         if (hold_busy) chk(!req_ready, "R6 not ready while busy", 32'(req_ready), 32'd0);
         @(negedge clk);
         wait_n++;
      end
      req_valid = 1'b0;
      if (rsp_valid) begin
         got_resp  = 1'b1;
         got_paddr = rsp_paddr;
         got_fault = rsp_fault;
         got_vpn   = rsp_vpn;
      end
      chk(got_resp, "R5 response arrives", 32'(got_resp), 32'd1);
      chk(cap_addr == exp_entry_addr(b, va), "R2 entry address", cap_addr, exp_entry_addr(b, va));
      chk(nreq - n0 == 1, "R2 one read per request", 32'(nreq - n0), 32'd1);
      @(negedge clk);
      chk(!rsp_valid, "R5 response lasts one cycle", 32'(rsp_valid), 32'd0);
      chk(!rsp_fault && rsp_paddr == 0 && rsp_vpn == 0, "R9 quiet after response",
          rsp_paddr | 32'(rsp_vpn), 32'd0);
   endtask

   task automatic check_result(input logic [31:0] b, input logic [31:0] va, input string tag);
      logic [31:0] pte;
      pte = lookup(exp_entry_addr(b, va));
      if (pte[0]) begin
         chk(!got_fault, {tag, " R3 no fault"}, 32'(got_fault), 32'd0);
         chk(got_paddr == exp_paddr(pte, va), {tag, " R3 physical address"}, got_paddr, exp_paddr(pte, va));
      end else begin
         chk(got_fault, {tag, " R4 fault raised"}, 32'(got_fault), 32'd1);
         chk(got_paddr == 0, {tag, " R4 no address"}, got_paddr, 32'd0);
         chk(got_vpn == va[31:12], {tag, " R4 faulting page"}, 32'(got_vpn), 32'(va[31:12]));
      end
   endtask

   initial begin
      void'($urandom(32'd4242));
      rst = 1'b1;
      req_valid = 1'b0;
      req_vaddr = 32'h0;
      req_base  = 32'h0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(req_ready && !mem_req && !rsp_valid && !rsp_fault, "R1 reset controls",
          {28'd0, req_ready, mem_req, rsp_valid, rsp_fault}, 32'h8);
      chk(rsp_paddr == 0 && rsp_vpn == 0, "R1 reset data", rsp_paddr | 32'(rsp_vpn), 32'd0);

      // R8 worked example
      ptm[32'h0001_0000] = 32'h0000_5001;
      translate(32'h0001_0000, 32'h0000_000A, 1'b0);
      chk(got_paddr == 32'h0000_500A && !got_fault, "R8 example", got_paddr, 32'h0000_500A);

      // R4 unmapped page
      translate(32'h0001_0000, 32'h0003_4ABC, 1'b0);
      check_result(32'h0001_0000, 32'h0003_4ABC, "unmapped");

      // R7 junk in bits 11:1
      ptm[32'h0002_0000 + 32'h0000_0004 * 32'h77] = 32'hABCD_EFFF;
      translate(32'h0002_0000, 32'h0007_7123, 1'b0);
      chk(got_paddr == 32'hABCD_E123, "R7 low entry bits ignored", got_paddr, 32'hABCD_E123);
      ptm[32'h0002_0000 + 32'h0000_0004 * 32'h78] = 32'h1234_5FFE;
      translate(32'h0002_0000, 32'h0007_8FFF, 1'b0);
      chk(got_fault && got_paddr == 0, "R7 clear flag still faults", got_paddr, 32'd0);

      // R6 request held during a walk
      ptm[32'h0003_0000 + 32'h0000_0004 * 32'hFFFFF] = 32'hFFFF_F001;
      translate(32'h0003_0000, 32'hFFFF_F800, 1'b1);
      check_result(32'h0003_0000, 32'hFFFF_F800, "busy");

      // R10 reset during a walk
      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = 32'h0000_000A;
      req_base  = 32'h0001_0000;
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(req_ready && !rsp_valid && !mem_req, "R10 abandoned after reset",
          {29'd0, req_ready, rsp_valid, mem_req}, 32'h4);
      repeat (6) begin
         @(negedge clk);
         chk(!rsp_valid, "R10 no late response", 32'(rsp_valid), 32'd0);
      end
      translate(32'h0001_0000, 32'h0000_000A, 1'b0);
      chk(got_paddr == 32'h0000_500A, "R10 recovers", got_paddr, 32'h0000_500A);

      // random translations
      for (int i = 0; i < 200; i++) begin
         logic [31:0] b;
         logic [31:0] va;
         logic [31:0] pte;
         b  = $urandom & 32'hFFFF_FFFC;
         va = $urandom;
         pte = $urandom;
         if ($urandom % 10 < 7) pte[0] = 1'b1; else pte[0] = 1'b0;
         ptm[exp_entry_addr(b, va)] = pte;
         translate(b, va, ($urandom % 8) == 0);
         check_result(b, va, "random");
      end
      finish_run();
   end

   initial begin
      wait (cycles > 100000);
      errors++;
      checks++;
      $display("FAIL watchdog R5 actual=timeout expected=completion");
      finish_run();
   end
endmodule